// File: doc/BRIEF.md
# Multi-address receive cell FIFO

This block sits between the cell sources of a receive path and a byte-wide ATM-layer output port. Cells arrive one byte per cycle, tagged with one of eight PHY addresses, and are stored in a separate cell queue for each address. A queue holds two cells when its address is configured as a UNI address and four cells when it is configured as an IMA group address. The type of each address comes from a static configuration input.

On the output side, the block presents one cell at a time, byte by byte, with a start-of-cell flag on the first byte and the address of the cell alongside it. The downstream device controls the flow with an active-low enable. When more than one queue holds cells, the lowest-numbered address wins, and a cell that has started is always completed before another address is served.

A cell that arrives for a full queue is dropped whole. The drop sets a sticky overflow bit for that address. Software clears a bit by writing 0 to it. Each bit has an interrupt enable, and the interrupt output is raised while any enabled bit is set.

Top module: `rxq_top`

## Requirements
- R1: Each of the eight addresses has its own queue. A cell written to address a is later delivered with rx_addr_o equal to a, with its bytes in the order they were written, and cells of one address leave in arrival order.
- R2: Bit a of cfg_ima_i selects the capacity of address a: 0 gives 2 cells (UNI), 1 gives 4 cells (IMA group).
- R3: A cell whose start-of-cell byte arrives while its queue holds its full capacity of cells is dropped in its entirety. None of its bytes is ever delivered, and the cells already queued are unaffected.
- R4: Every delivered cell is 53 bytes long. rx_soc_o is 1 on the first byte only, and rx_addr_o stays constant across all bytes of the cell.
- R5: A byte is transferred only on a clock edge where rx_valid_o is 1 and rx_enb_ni is 0. While rx_enb_ni is 1 in the middle of a cell, rx_valid_o, rx_addr_o and rx_data_o hold their values.
- R6: When a new cell is about to start, the non-empty queue with the lowest address is selected. Once a cell has started, it runs to completion even if a lower-numbered queue becomes non-empty.
- R7: A dropped cell sets bit a of ovf_sts_o (for address a) in the cycle after its start byte. The bit stays set until it is cleared.
- R8: A cycle with sts_clr_we_i at 1 clears each status bit whose bit in sts_clr_data_i is 0, as long as no overflow occurs on that address in the same cycle. Status bits whose write data is 1 are left unchanged.
- R9: irq_o is 1 exactly when some bit is set in both ovf_sts_o and irq_en_i.
- R10: After reset, all queues are empty, rx_valid_o is 0, ovf_sts_o is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ima_i | input | 8 | Static per-address type: 1 = IMA group (4 cells), 0 = UNI (2 cells) |
| in_valid_i | input | 1 | Input byte valid |
| in_soc_i | input | 1 | Input byte is the first byte of a cell |
| in_addr_i | input | 3 | Address of the cell, sampled with the start byte |
| in_data_i | input | 8 | Input cell byte |
| rx_enb_ni | input | 1 | Downstream enable, active low |
| rx_valid_o | output | 1 | Output byte valid |
| rx_soc_o | output | 1 | Output byte is the first byte of a cell |
| rx_addr_o | output | 3 | Address of the cell being delivered |
| rx_data_o | output | 8 | Output cell byte |
| sts_clr_we_i | input | 1 | Status write strobe |
| sts_clr_data_i | input | 8 | Status write data; 0 bits clear |
| irq_en_i | input | 8 | Per-address interrupt enable |
| ovf_sts_o | output | 8 | Sticky per-address overflow status |
| irq_o | output | 1 | Interrupt: OR of status AND enable |

## Verification
The bench builds the block with its default parameters: eight addresses, 53-byte cells, and capacities of 2 and 4 cells. cfg_ima_i is set to 8'hAA, so that the even addresses get the UNI depth and the odd addresses get the IMA depth. This lets the bench drive one queue of each kind past its capacity and then drain it, and it lets it check that the lowest-address choice works across queues of both depths. The full cell length also gives room to pause the output in the middle of a cell and to queue a lower-numbered address while another cell is still being sent.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef logic [7:0] byte_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rxq_cell_queue.sv
module rxq_cell_queue
  import rxq_pkg::*;
#(
  parameter int unsigned MAX_CELLS  = 4,
  parameter int unsigned UNI_CELLS  = 2,
  parameter int unsigned IMA_CELLS  = 4,
  parameter int unsigned CELL_BYTES = 53,
  localparam int unsigned IW  = $clog2(CELL_BYTES),
  localparam int unsigned SW  = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1,
  localparam int unsigned CW  = $clog2(MAX_CELLS + 1),
  localparam int unsigned MW  = $clog2(MAX_CELLS * CELL_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ima_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  byte_t         wr_data_i,
  input  logic          wr_last_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic          pop_i,
  output byte_t         rd_data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned DEPTH = MAX_CELLS * CELL_BYTES;

  byte_t          mem_q [DEPTH];
  logic [SW-1:0]  wptr_q, rptr_q;
  logic [CW-1:0]  cnt_q, cap;
  logic [MW-1:0]  waddr, raddr;
  logic           commit;

  assign cap     = ima_i ? CW'(IMA_CELLS) : CW'(UNI_CELLS);
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q >= cap);
  assign commit  = wr_en_i & wr_last_i;

  assign waddr = MW'(wptr_q) * MW'(CELL_BYTES) + MW'(wr_idx_i);
  assign raddr = MW'(rptr_q) * MW'(CELL_BYTES) + MW'(rd_idx_i);
  assign rd_data_o = mem_q[raddr];

  function automatic logic [SW-1:0] bump(input logic [SW-1:0] p, input logic [CW-1:0] c);
    return (CW'(p) + CW'(1) >= c) ? '0 : p + SW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[waddr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (commit) wptr_q <= bump(wptr_q, cap);
      if (pop_i)  rptr_q <= bump(rptr_q, cap);
      case ({commit, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R2
  cnt_le_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cap);

  // R3
  commit_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && !pop_i |-> cnt_q < cap);

  // R1
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
  import rxq_pkg::*;
#(
  parameter int unsigned NUM_ADDR   = 8,
  parameter int unsigned CELL_BYTES = 53,
  localparam int unsigned AW = $clog2(NUM_ADDR),
  localparam int unsigned IW = $clog2(CELL_BYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic                in_soc_i,
  input  logic [AW-1:0]       in_addr_i,
  input  byte_t               in_data_i,
  input  logic [NUM_ADDR-1:0] full_i,
  output logic [NUM_ADDR-1:0] wr_en_o,
  output logic [IW-1:0]       wr_idx_o,
  output byte_t               wr_data_o,
  output logic                wr_last_o,
  output logic [NUM_ADDR-1:0] ovf_o
);
  logic          act_q, drop_q;
  logic [AW-1:0] addr_q, eff_addr;
  logic [IW-1:0] idx_q, eff_idx;
  logic          start, live, eff_drop;

  assign start    = in_valid_i & in_soc_i;
  assign live     = in_valid_i & (start | act_q);
  assign eff_addr = start ? in_addr_i : addr_q;
  assign eff_idx  = start ? '0 : idx_q;
  assign eff_drop = start ? full_i[in_addr_i] : drop_q;

  assign wr_idx_o  = eff_idx;
  assign wr_data_o = in_data_i;
  assign wr_last_o = (eff_idx == IW'(CELL_BYTES - 1));

  always_comb begin
    wr_en_o = '0;
    ovf_o   = '0;
    if (live && !eff_drop) wr_en_o[eff_addr] = 1'b1;
    if (start && full_i[in_addr_i]) ovf_o[in_addr_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      drop_q <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
    end else if (live) begin
      act_q  <= ~wr_last_o;
      drop_q <= eff_drop;
      addr_q <= eff_addr;
      idx_q  <= eff_idx + IW'(1);
    end
  end

  // R1
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));

  // R3
  drop_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o != '0) |=> (wr_en_o == '0) || (in_valid_i && in_soc_i));
endmodule

// File: rtl/rxq_reader.sv
module rxq_reader #(
  parameter int unsigned NUM_ADDR   = 8,
  parameter int unsigned CELL_BYTES = 53,
  localparam int unsigned AW = $clog2(NUM_ADDR),
  localparam int unsigned IW = $clog2(CELL_BYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_ADDR-1:0] empty_i,
  input  logic                enb_ni,
  output logic                valid_o,
  output logic                soc_o,
  output logic [AW-1:0]       addr_o,
  output logic [IW-1:0]       rd_idx_o,
  output logic [NUM_ADDR-1:0] pop_o
);
  logic          busy_q;
  logic [AW-1:0] cur_q, low;
  logic [IW-1:0] idx_q;
  logic          any, xfer, last;

  always_comb begin
    low = '0;
    for (int i = NUM_ADDR - 1; i >= 0; i--)
      if (!empty_i[i]) low = AW'(i);
  end

  assign any      = ~&empty_i;
  assign addr_o   = busy_q ? cur_q : low;
  assign rd_idx_o = busy_q ? idx_q : '0;
  assign valid_o  = busy_q | any;
  assign soc_o    = valid_o & (rd_idx_o == '0);
  assign xfer     = valid_o & ~enb_ni;
  assign last     = (rd_idx_o == IW'(CELL_BYTES - 1));

  always_comb begin
    pop_o = '0;
    if (xfer && last) pop_o[addr_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      idx_q  <= '0;
    end else if (xfer) begin
      busy_q <= ~last;
      cur_q  <= addr_o;
      idx_q  <= last ? '0 : rd_idx_o + IW'(1);
    end
  end

  // R5
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && enb_ni |=> valid_o && $stable(addr_o) && $stable(rd_idx_o));

  // R6
  cell_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer && !last |=> valid_o && !soc_o && addr_o == $past(addr_o));

  // R4
  single_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o));
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int unsigned NUM_ADDR = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_ADDR-1:0] ovf_i,
  input  logic                clr_we_i,
  input  logic [NUM_ADDR-1:0] clr_data_i,
  input  logic [NUM_ADDR-1:0] irq_en_i,
  output logic [NUM_ADDR-1:0] sts_o,
  output logic                irq_o
);
  logic [NUM_ADDR-1:0] sts_q, clr;

  assign clr   = clr_we_i ? ~clr_data_i : '0;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & irq_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr) | ovf_i;
  end

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_chk
    // R7
    sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[k] |=> sts_o[k]);
    // R8
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i && !clr_data_i[k] && !ovf_i[k] |=> !sts_o[k]);
    // R8
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_o[k] && !(clr_we_i && !clr_data_i[k]) |=> sts_o[k]);
  end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned NUM_ADDR   = 8,
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned UNI_CELLS  = 2,
  parameter int unsigned IMA_CELLS  = 4,
  localparam int unsigned AW        = $clog2(NUM_ADDR),
  localparam int unsigned IW        = $clog2(CELL_BYTES),
  localparam int unsigned MAX_CELLS = max_u(UNI_CELLS, IMA_CELLS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_ADDR-1:0] cfg_ima_i,
  input  logic                in_valid_i,
  input  logic                in_soc_i,
  input  logic [AW-1:0]       in_addr_i,
  input  logic [7:0]          in_data_i,
  input  logic                rx_enb_ni,
  output logic                rx_valid_o,
  output logic                rx_soc_o,
  output logic [AW-1:0]       rx_addr_o,
  output logic [7:0]          rx_data_o,
  input  logic                sts_clr_we_i,
  input  logic [NUM_ADDR-1:0] sts_clr_data_i,
  input  logic [NUM_ADDR-1:0] irq_en_i,
  output logic [NUM_ADDR-1:0] ovf_sts_o,
  output logic                irq_o
);
  logic [NUM_ADDR-1:0] full, empty, wr_en, pop, ovf;
  logic [IW-1:0]       wr_idx, rd_idx;
  byte_t               wr_data;
  logic                wr_last;
  byte_t               rd_data [NUM_ADDR];

  rxq_writer #(.NUM_ADDR(NUM_ADDR), .CELL_BYTES(CELL_BYTES)) u_wr (
    .clk_i, .rst_ni,
    .in_valid_i, .in_soc_i, .in_addr_i, .in_data_i,
    .full_i(full), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .wr_last_o(wr_last), .ovf_o(ovf)
  );

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_q
    rxq_cell_queue #(
      .MAX_CELLS(MAX_CELLS), .UNI_CELLS(UNI_CELLS),
      .IMA_CELLS(IMA_CELLS), .CELL_BYTES(CELL_BYTES)
    ) u_q (
      .clk_i, .rst_ni,
      .ima_i(cfg_ima_i[a]),
      .wr_en_i(wr_en[a]), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_last_i(wr_last),
      .rd_idx_i(rd_idx), .pop_i(pop[a]), .rd_data_o(rd_data[a]),
      .empty_o(empty[a]), .full_o(full[a])
    );
  end

  rxq_reader #(.NUM_ADDR(NUM_ADDR), .CELL_BYTES(CELL_BYTES)) u_rd (
    .clk_i, .rst_ni,
    .empty_i(empty), .enb_ni(rx_enb_ni),
    .valid_o(rx_valid_o), .soc_o(rx_soc_o), .addr_o(rx_addr_o),
    .rd_idx_o(rd_idx), .pop_o(pop)
  );

  assign rx_data_o = rd_data[rx_addr_o];

  rxq_status #(.NUM_ADDR(NUM_ADDR)) u_sts (
    .clk_i, .rst_ni,
    .ovf_i(ovf), .clr_we_i(sts_clr_we_i), .clr_data_i(sts_clr_data_i),
    .irq_en_i, .sts_o(ovf_sts_o), .irq_o
  );

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_sts_o != '0);

  // R10
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> !rx_soc_o && (pop == '0));
endmodule

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
  logic       clk = 0, rst_n = 0;
  logic [7:0] cfg_ima = 8'hAA;
  logic       in_valid = 0, in_soc = 0;
  logic [2:0] in_addr = 0;
  logic [7:0] in_data = 0;
  logic       rx_enb_n = 1;
  logic       rx_valid, rx_soc;
  logic [2:0] rx_addr;
  logic [7:0] rx_data;
  logic       clr_we = 0;
  logic [7:0] clr_data = 8'hFF, irq_en = 0, ovf_sts;
  logic       irq;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  rxq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ima_i(cfg_ima),
    .in_valid_i(in_valid), .in_soc_i(in_soc), .in_addr_i(in_addr), .in_data_i(in_data),
    .rx_enb_ni(rx_enb_n), .rx_valid_o(rx_valid), .rx_soc_o(rx_soc),
    .rx_addr_o(rx_addr), .rx_data_o(rx_data),
    .sts_clr_we_i(clr_we), .sts_clr_data_i(clr_data), .irq_en_i(irq_en),
    .ovf_sts_o(ovf_sts), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_cell(input int addr, input int seed);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      in_valid = 1; in_soc = (i == 0); in_addr = 3'(addr); in_data = 8'(seed + i);
    end
    @(negedge clk);
    in_valid = 0; in_soc = 0;
  endtask

  // takes one cell; stall_at pauses before that byte index (-1: none)
  task automatic take_cell(input int addr, input int seed, input int stall_at, input string req);
    int bad_i = -1, act = 0, exp = 0;
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      if (i == stall_at) begin
        logic [7:0] d0;
        logic [2:0] a0;
        rx_enb_n = 1;
        d0 = rx_data; a0 = rx_addr;
        repeat (3) @(negedge clk);
        check(rx_valid && rx_data == d0 && rx_addr == a0, "R5 pause hold",
              {rx_valid, rx_addr, rx_data}, {1'b1, a0, d0});
      end
      rx_enb_n = 0;
      if (bad_i < 0 && !(rx_valid && rx_addr == 3'(addr) && rx_data == 8'(seed + i)
                         && rx_soc == (i == 0))) begin
        bad_i = i;
        act = {rx_valid, rx_soc, 1'b0, rx_addr, rx_data};
        exp = {1'b1, i == 0, 1'b0, 3'(addr), 8'(seed + i)};
      end
    end
    @(negedge clk);
    rx_enb_n = 1;
    check(bad_i < 0, req, act, exp);
  endtask

  task automatic t_reset();
    check(!rx_valid, "R10 valid after reset", rx_valid, 0);
    check(ovf_sts == 0, "R10 status after reset", ovf_sts, 0);
    check(!irq, "R10 irq after reset", irq, 0);
  endtask

  task automatic t_single();
    send_cell(3, 8'h10);
    take_cell(3, 8'h10, -1, "R1 R4 single cell addr 3");
    check(!rx_valid, "R1 empty after drain", rx_valid, 0);
  endtask

  task automatic t_overflow();
    for (int c = 0; c < 3; c++) send_cell(0, 8'h20 + 8'(c * 8));
    check(ovf_sts == 8'h01, "R2 R3 R7 UNI overflow at third cell", ovf_sts, 8'h01);
    for (int c = 0; c < 5; c++) send_cell(1, 8'h60 + 8'(c * 8));
    check(ovf_sts == 8'h03, "R2 R7 IMA overflow at fifth cell", ovf_sts, 8'h03);
    irq_en = 8'h00;
    @(negedge clk);
    check(!irq, "R9 irq masked", irq, 0);
    irq_en = 8'h02;
    @(negedge clk);
    check(irq, "R9 irq enabled bit 1", irq, 1);
    for (int c = 0; c < 2; c++) take_cell(0, 8'h20 + c * 8, -1, "R6 R2 addr 0 first");
    for (int c = 0; c < 4; c++) take_cell(1, 8'h60 + c * 8, -1, "R2 R3 addr 1 four cells");
    check(!rx_valid, "R3 dropped cells never delivered", rx_valid, 0);
    check(ovf_sts == 8'h03, "R7 status sticky", ovf_sts, 8'h03);
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr_we = 1; clr_data = 8'hFE;
    @(negedge clk);
    clr_we = 0; clr_data = 8'hFF;
    check(ovf_sts == 8'h02, "R8 clear bit 0 only", ovf_sts, 8'h02);
    irq_en = 8'h01;
    @(negedge clk);
    check(!irq, "R9 irq after clear", irq, 0);
    clr_we = 1; clr_data = 8'h00;
    @(negedge clk);
    clr_we = 0; clr_data = 8'hFF;
    check(ovf_sts == 8'h00, "R8 clear all", ovf_sts, 0);
    irq_en = 8'h00;
  endtask

  task automatic t_pause();
    send_cell(6, 8'hA0);
    take_cell(6, 8'hA0, 20, "R5 paused cell intact");
  endtask

  task automatic t_no_preempt();
    send_cell(5, 8'h40);
    fork
      take_cell(5, 8'h40, 30, "R6 cell not interrupted");
      begin
        repeat (3) @(negedge clk);
        send_cell(2, 8'hC0);
      end
    join
    take_cell(2, 8'hC0, -1, "R6 lower address served next");
    send_cell(7, 8'h01);
    send_cell(4, 8'h81);
    take_cell(4, 8'h81, -1, "R6 lowest non-empty chosen");
    take_cell(7, 8'h01, -1, "R1 addr 7 after addr 4");
    check(ovf_sts == 0, "R3 no overflow within capacity", ovf_sts, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_overflow();
    t_clear();
    t_pause();
    t_no_preempt();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule